// File: doc/BRIEF.md
# Six-Pin Bidirectional GPIO Port Controller

This block is a memory-mapped general-purpose I/O port for six pads. Software sees it through a small register bus: a direction register, an output data latch, a control register with a global pull-up disable, and a read-only address that returns the synchronized logic levels on the pads. From the direction and latch bits the block computes, per pin, a tri-state output enable, a drive value and a pull-up enable for the pad cell.

Two system conditions are applied on top of the register state. Four pins share their pads with analog inputs. In the deep sleep modes (power-down and noise-reduction) their digital input buffers are cut off, so their sampled value reads as 0. This way a pad resting near mid-supply draws no crossover current. One pin can also be claimed as an external reset input. While that override is active, the pin is never driven and its latch cannot turn on its pull-up, whatever the direction and latch bits say.

Top module: `gpio_port`

## Requirements
- R1: Each pin's output enable equals its direction bit (1 = output, 0 = input), except that the reset-capable pin (index 5) has its enable forced to 0 while the override is active.
- R2: Each pin's pad drive value equals its output-latch bit. The overridden reset pin drives 0.
- R3: A pin's pull-up enable is 1 only when the pin is an input and its latch bit is 1. Clearing the latch or setting the direction to output turns it off.
- R4: When control bit 0 (pull-up disable) is 1, every pull-up enable is 0, whatever the direction and latch bits are.
- R5: Reading address 1 returns the direction register and reading address 2 returns the stored latch contents, never the pad levels.
- R6: Reading address 0 returns the pad levels sampled by a two-stage synchronizer, so the value shown is the pad state two clock edges earlier.
- R7: For the analog-shared pins (indices 2 to 5), address 0 reads 0 while the sleep mode is 2 (power-down) or 3 (noise-reduction). Sleep modes 0 (active) and 1 (idle) and pins 0 to 1 are unaffected.
- R8: While the reset override input is 1, pin 5 has output enable 0 and pull-up enable 0, whatever its direction and latch bits are.
- R9: Writes to address 0 change no register.
- R10: After reset the direction, latch and control registers are 0 and the synchronizer stages are 0: every pin is an input with its pull-up off.
- R11: Address 3 reads the pull-up-disable bit in bit 0 and zeros in all other bits. Writes there store write-data bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Port clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 2 | Register address (0 pin sample, 1 direction, 2 latch, 3 control) |
| bus_wdata_i | input | 6 | Write data |
| bus_we_i | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_rdata_o | output | 6 | Combinational read data for bus_addr_i |
| pad_in_i | input | 6 | Pad input levels (asynchronous) |
| pad_oe_o | output | 6 | Per-pin output enable for the pad driver |
| pad_out_o | output | 6 | Per-pin drive value |
| pad_pue_o | output | 6 | Per-pin pull-up enable |
| sleep_mode_i | input | 2 | Sleep mode: 0 active, 1 idle, 2 power-down, 3 noise-reduction |
| rst_ovr_i | input | 1 | Hands pin 5 over to the external reset function |

## Verification
On every cycle the assertions check four things: a pull-up is never enabled on a pin that is driving; the disable bit leaves no pull-up on; the overridden reset pin stays undriven and unpulled; and analog-shared pins read 0 in the deep sleep modes. They also check that a write to the sample address leaves the direction and latch registers unchanged, and that the sample read matches the pad history two edges back. Only the bench's scenarios can show that the computed pad controls match the full register model across random mixes of writes, modes and overrides. The same holds for the latch readback being independent of the pad levels and for the reset values seen at the ports.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_PINS = 2'd0,
    A_DIR  = 2'd1,
    A_LAT  = 2'd2,
    A_CTL  = 2'd3
  } gpio_addr_e;

  typedef enum logic [1:0] {
    SLP_ACTIVE = 2'd0,
    SLP_IDLE   = 2'd1,
    SLP_PWRDN  = 2'd2,
    SLP_NOISE  = 2'd3
  } gpio_sleep_e;

  function automatic logic deep_sleep(input logic [1:0] mode);
    return (mode == SLP_PWRDN) || (mode == SLP_NOISE);
  endfunction
endpackage

// File: rtl/gpio_rstsync.sv
module gpio_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPINS-1:0] wdata_i,
  input  logic             we_i,
  output logic [NPINS-1:0] dir_o,
  output logic [NPINS-1:0] lat_o,
  output logic             pud_o
);
  logic [NPINS-1:0] dir_q, dir_d;
  logic [NPINS-1:0] lat_q, lat_d;
  logic             pud_q, pud_d;
  logic             dir_en, lat_en, ctl_en;

  always_comb begin
    dir_en = we_i && (addr_i == A_DIR);
    lat_en = we_i && (addr_i == A_LAT);
    ctl_en = we_i && (addr_i == A_CTL);
    dir_d  = dir_en ? wdata_i    : dir_q;
    lat_d  = lat_en ? wdata_i    : lat_q;
    pud_d  = ctl_en ? wdata_i[0] : pud_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      lat_q <= '0;
      pud_q <= 1'b0;
    end else begin
      dir_q <= dir_d;
      lat_q <= lat_d;
      pud_q <= pud_d;
    end
  end

  assign dir_o = dir_q;
  assign lat_o = lat_q;
  assign pud_o = pud_q;
endmodule

// File: rtl/gpio_insync.sv
module gpio_insync
  import gpio_pkg::*;
#(
  parameter int unsigned    NPINS    = 6,
  parameter logic [NPINS-1:0] ANA_MASK = 6'b111100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pad_i,
  input  logic [1:0]       sleep_i,
  output logic [NPINS-1:0] sample_o
);
  logic [NPINS-1:0] s1_q, s2_q;
  logic             cut;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= pad_i;
      s2_q <= s1_q;
    end
  end

  assign cut = deep_sleep(sleep_i);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    if (ANA_MASK[i]) begin : g_ana
      assign sample_o[i] = s2_q[i] & ~cut;
    end else begin : g_dig
      assign sample_o[i] = s2_q[i];
    end
  end
endmodule

// File: rtl/gpio_padctl.sv
module gpio_padctl #(
  parameter int unsigned NPINS   = 6,
  parameter int unsigned RST_PIN = 5
) (
  input  logic [NPINS-1:0] dir_i,
  input  logic [NPINS-1:0] lat_i,
  input  logic             pud_i,
  input  logic             ovr_i,
  output logic [NPINS-1:0] oe_o,
  output logic [NPINS-1:0] out_o,
  output logic [NPINS-1:0] pue_o
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic owned;
    if (i == RST_PIN) begin : g_rst
      assign owned = ~ovr_i;
    end else begin : g_gen
      assign owned = 1'b1;
    end
    assign oe_o[i]  = owned & dir_i[i];
    assign out_o[i] = owned & lat_i[i];
    assign pue_o[i] = owned & ~pud_i & ~dir_i[i] & lat_i[i];
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned      NPINS    = 6,
  parameter logic [NPINS-1:0] ANA_MASK = 6'b111100,
  parameter int unsigned      RST_PIN  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       bus_addr_i,
  input  logic [NPINS-1:0] bus_wdata_i,
  input  logic             bus_we_i,
  output logic [NPINS-1:0] bus_rdata_o,
  input  logic [NPINS-1:0] pad_in_i,
  output logic [NPINS-1:0] pad_oe_o,
  output logic [NPINS-1:0] pad_out_o,
  output logic [NPINS-1:0] pad_pue_o,
  input  logic [1:0]       sleep_mode_i,
  input  logic             rst_ovr_i
);
  logic             rst_n;
  logic [NPINS-1:0] dir_w, lat_w, smp_w;
  logic             pud_w;

  gpio_rstsync #(.STAGES(2)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_sync_no(rst_n)
  );

  gpio_regs #(.NPINS(NPINS)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_n), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .we_i(bus_we_i),
    .dir_o(dir_w), .lat_o(lat_w), .pud_o(pud_w)
  );

  gpio_insync #(.NPINS(NPINS), .ANA_MASK(ANA_MASK)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_n), .pad_i(pad_in_i),
    .sleep_i(sleep_mode_i), .sample_o(smp_w)
  );

  gpio_padctl #(.NPINS(NPINS), .RST_PIN(RST_PIN)) u_pad (
    .dir_i(dir_w), .lat_i(lat_w), .pud_i(pud_w), .ovr_i(rst_ovr_i),
    .oe_o(pad_oe_o), .out_o(pad_out_o), .pue_o(pad_pue_o)
  );

  always_comb begin
    unique case (bus_addr_i)
      A_PINS:  bus_rdata_o = smp_w;
      A_DIR:   bus_rdata_o = dir_w;
      A_LAT:   bus_rdata_o = lat_w;
      default: bus_rdata_o = {{(NPINS-1){1'b0}}, pud_w};
    endcase
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_pkg::*;
#(
  parameter int unsigned      NPINS    = 6,
  parameter logic [NPINS-1:0] ANA_MASK = 6'b111100,
  parameter int unsigned      RST_PIN  = 5
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic [1:0]       bus_addr_i,
  input logic             bus_we_i,
  input logic [NPINS-1:0] bus_rdata_o,
  input logic [NPINS-1:0] pad_in_i,
  input logic [NPINS-1:0] pad_oe_o,
  input logic [NPINS-1:0] pad_pue_o,
  input logic [1:0]       sleep_mode_i,
  input logic             rst_ovr_i,
  input logic [NPINS-1:0] dir_w,
  input logic [NPINS-1:0] lat_w,
  input logic             pud_w
);
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)             age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  a_r3_no_pull_on_driver: assert property (@(posedge clk_i) disable iff (!rst_n)
    (pad_pue_o & pad_oe_o) == '0);

  a_r4_disable_all_pulls: assert property (@(posedge clk_i) disable iff (!rst_n)
    pud_w |-> (pad_pue_o == '0));

  a_r8_reset_pin_free: assert property (@(posedge clk_i) disable iff (!rst_n)
    rst_ovr_i |-> (!pad_oe_o[RST_PIN] && !pad_pue_o[RST_PIN]));

  a_r7_analog_cut: assert property (@(posedge clk_i) disable iff (!rst_n)
    (deep_sleep(sleep_mode_i) && bus_addr_i == A_PINS) |-> ((bus_rdata_o & ANA_MASK) == '0));

  a_r9_pin_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_we_i && bus_addr_i == A_PINS) |=> ($stable(dir_w) && $stable(lat_w) && $stable(pud_w)));

  a_r6_two_stage_delay: assert property (@(posedge clk_i) disable iff (!rst_n)
    (age_q == 2'd3 && bus_addr_i == A_PINS && sleep_mode_i == SLP_ACTIVE)
      |-> (bus_rdata_o == $past(pad_in_i, 2)));
endmodule

bind gpio_port gpio_port_chk #(.NPINS(NPINS), .ANA_MASK(ANA_MASK), .RST_PIN(RST_PIN)) u_chk (
  .clk_i(clk_i), .rst_n(rst_n), .bus_addr_i(bus_addr_i), .bus_we_i(bus_we_i),
  .bus_rdata_o(bus_rdata_o), .pad_in_i(pad_in_i), .pad_oe_o(pad_oe_o),
  .pad_pue_o(pad_pue_o), .sleep_mode_i(sleep_mode_i), .rst_ovr_i(rst_ovr_i),
  .dir_w(dir_w), .lat_w(lat_w), .pud_w(pud_w)
);

// File: tb/gpio_port_tb_top.sv
module gpio_port_tb_top;
  localparam int NP = 6;
  localparam logic [NP-1:0] ANA = 6'b111100;
  localparam int RP = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    addr = '0;
  logic [NP-1:0] wdata = '0;
  logic          we = 1'b0;
  logic [NP-1:0] rdata, oe, dout, pue;
  logic [NP-1:0] pad = '0;
  logic [1:0]    slp = '0;
  logic          ovr = 1'b0;

  int errors = 0;
  int checks = 0;
  logic [NP-1:0] m_dir = '0, m_lat = '0;
  logic          m_pud = 1'b0;
  logic          done = 1'b0;

  always #4 clk = ~clk;

  gpio_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_we_i(we), .bus_rdata_o(rdata), .pad_in_i(pad), .pad_oe_o(oe),
    .pad_out_o(dout), .pad_pue_o(pue), .sleep_mode_i(slp), .rst_ovr_i(ovr)
  );

  function automatic logic [NP-1:0] own_mask(input logic o);
    return o ? ~(NP'(1) << RP) : '1;
  endfunction
  function automatic logic [NP-1:0] e_oe(input logic [NP-1:0] d, input logic o);
    return d & own_mask(o);
  endfunction
  function automatic logic [NP-1:0] e_out(input logic [NP-1:0] l, input logic o);
    return l & own_mask(o);
  endfunction
  function automatic logic [NP-1:0] e_pue(input logic [NP-1:0] d, input logic [NP-1:0] l,
                                          input logic p, input logic o);
    return p ? '0 : (~d & l & own_mask(o));
  endfunction
  function automatic logic [NP-1:0] e_pins(input logic [NP-1:0] p, input logic [1:0] s);
    return (s >= 2'd2) ? (p & ~ANA) : p;
  endfunction
  function automatic logic [NP-1:0] e_read(input logic [1:0] a, input logic [NP-1:0] p,
                                           input logic [1:0] s);
    case (a)
      2'd0: return e_pins(p, s);
      2'd1: return m_dir;
      2'd2: return m_lat;
      default: return {{(NP-1){1'b0}}, m_pud};
    endcase
  endfunction

  task automatic chk(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // one bus step: write (optional), hold pads two edges, then check at negedge
  task automatic step(input logic w, input logic [1:0] a, input logic [NP-1:0] d,
                      input logic [NP-1:0] p, input logic [1:0] s, input logic o,
                      input logic [1:0] ra);
    @(negedge clk);
    we = w; addr = a; wdata = d; pad = p; slp = s; ovr = o;
    @(negedge clk);
    if (w) begin
      if (a == 2'd1) m_dir = d;
      else if (a == 2'd2) m_lat = d;
      else if (a == 2'd3) m_pud = d[0];
    end
    we = 1'b0;
    @(negedge clk);
    addr = ra;
    #1;
    chk("R1/R8 oe", oe, e_oe(m_dir, o));
    chk("R2 out", dout, e_out(m_lat, o));
    chk("R3/R4 pue", pue, e_pue(m_dir, m_lat, m_pud, o));
    chk("R5/R6/R7/R11 read", rdata, e_read(ra, p, s));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    pad = 6'b101101;
    repeat (3) @(negedge clk);
    // R10: reset state
    addr = 2'd0; #1; chk("R10 pin sample", rdata, '0);
    addr = 2'd1; #1; chk("R10 dir", rdata, '0);
    addr = 2'd2; #1; chk("R10 lat", rdata, '0);
    addr = 2'd3; #1; chk("R10 ctl", rdata, '0);
    chk("R10 oe", oe, '0);
    chk("R10 pue", pue, '0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3: inputs with latch high get pull-ups
    step(1, 2'd2, 6'b111111, 6'b000000, 2'd0, 0, 2'd2);
    chk("R3 all inputs pulled", pue, 6'b111111);
    // R5: latch readback independent of pads
    step(0, 2'd0, 6'b0, 6'b000000, 2'd0, 0, 2'd2);
    chk("R5 latch not pads", rdata, 6'b111111);
    // R4: global disable
    step(1, 2'd3, 6'b000001, 6'b010101, 2'd0, 0, 2'd3);
    chk("R4 pulls off", pue, '0);
    chk("R11 ctl read", rdata, 6'b000001);
    // R11: only bit 0 stored
    step(1, 2'd3, 6'b111110, 6'b010101, 2'd0, 0, 2'd3);
    chk("R11 ctl bit0 only", rdata, 6'b000000);
    // R1/R3: outputs lose pull-ups
    step(1, 2'd1, 6'b000111, 6'b000000, 2'd0, 0, 2'd1);
    chk("R1 oe", oe, 6'b000111);
    chk("R3 output no pull", pue, 6'b111000);
    // R9: pin address write ignored
    step(1, 2'd0, 6'b101010, 6'b110011, 2'd0, 0, 2'd1);
    chk("R9 dir kept", rdata, 6'b000111);
    addr = 2'd2; #1; chk("R9 lat kept", rdata, 6'b111111);
    addr = 2'd3; #1; chk("R9 ctl kept", rdata, 6'b000000);
    // R8: override on output pin 5
    step(1, 2'd1, 6'b100000, 6'b000000, 2'd0, 1, 2'd1);
    chk("R8 pin5 undriven", oe[RP], 1'b0);
    step(1, 2'd1, 6'b000000, 6'b000000, 2'd0, 1, 2'd1);
    chk("R8 pin5 no pull", pue[RP], 1'b0);
    // R7: sleep gating in every mode
    for (int m = 0; m < 4; m++) begin
      step(0, 2'd0, 6'b0, 6'b111111, 2'(m), 0, 2'd0);
      chk("R7 sleep sample", rdata, (m >= 2) ? 6'b000011 : 6'b111111);
    end
    // R6: two-edge latency
    @(negedge clk); slp = 2'd0; addr = 2'd0; pad = 6'b000000;
    repeat (2) @(negedge clk);
    pad = 6'b110110;
    @(negedge clk); #1; chk("R6 one edge", rdata, 6'b000000);
    @(negedge clk); #1; chk("R6 two edges", rdata, 6'b110110);

    // random mix
    for (int i = 0; i < 400; i++) begin
      step(1'($urandom), 2'($urandom), NP'($urandom), NP'($urandom),
           2'($urandom), 1'($urandom), 2'($urandom));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule